// File: doc/BRIEF.md
# PDM Clock-Sensing Channel Selector

This block sits behind two raw digital input pins of a mono PDM speaker path. Either pin may carry the PDM bit clock while the other carries two interleaved audio channels. The block watches both pins through synchronizers, running on a fast oversampling system clock. It decides which pin is toggling regularly enough to be the bit clock and gives the other pin the data role. That decision fixes the channel: a clock on pin A plays the left channel, sampled on the clock's rising edge. A clock on pin B plays the right channel, sampled on the clock's falling edge.

The selected channel leaves the block as a 1-bit stream with a one-cycle valid strobe per captured bit. A clock-present flag and the chosen channel are also output. When the clock pin goes quiet for a timeout, the block clears its decision and detects the roles again from scratch. The two systems can therefore be swapped while the bus is stopped. The data pin must stay quiet while no clock runs, or the block can pick the wrong roles.

Top module: `pdm_role_sense`

## Requirements
- R1: When pin A is detected as the clock and pin B carries the data, `chan_right` reads 0 (left channel) while `clk_present` is 1.
- R2: When pin B is detected as the clock and pin A carries the data, `chan_right` reads 1 (right channel) while `clk_present` is 1.
- R3: In the left case the data pin is sampled on every rising edge of pin A; in the right case it is sampled on every falling edge of pin B. The sampled value appears on `pdm_bit`, with the strobe, three system cycles after the pin edge: two synchronizer stages plus one output register.
- R4: `clk_present` rises only when one pin has shown LOCK_EDGES consecutive transitions, each within MAX_GAP+1 system cycles of the previous one, and the other pin has not. If both pins qualify together, no assignment is made.
- R5: Once an assignment is made, it and `chan_right` are held while `clk_present` stays 1. After LOST_CYCLES system cycles with no transition on the clock pin, `clk_present` falls, `chan_right` returns to 0 and detection restarts.
- R6: `pdm_vld` pulses for exactly one cycle per captured bit of the selected channel and never while `clk_present` is 0.
- R7: While `rst_n` is low, `clk_present`, `chan_right`, `pdm_vld` and `pdm_bit` are 0.
- R8: A pin whose transitions are spaced more than MAX_GAP+1 system cycles apart never qualifies as the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_a | input | 1 | Raw input pin A (clock or data) |
| pin_b | input | 1 | Raw input pin B (clock or data) |
| pdm_bit | output | 1 | Captured bit of the selected channel |
| pdm_vld | output | 1 | One-cycle strobe per captured bit |
| clk_present | output | 1 | A bit clock is detected on one pin |
| chan_right | output | 1 | 1 = right channel selected, 0 = left or none |

## Verification
The bench builds the block with its default parameters: two synchronizer stages, a lock after 16 edges, a regular-edge gap of 16 and a loss timeout of 64 cycles. These values put a PDM clock with half periods of 4 to 6 system cycles well inside the lock window. A pin toggling every 24 cycles lies just outside it, and the loss timeout can be bracketed in a few hundred cycles. Sessions alternate the clock pin, so each session also tests that a stopped clock clears the previous assignment before the roles are swapped.

// File: rtl/pdm_sense_pkg.sv
package pdm_sense_pkg;
   typedef enum logic [1:0] {
      ROLE_NONE  = 2'd0,
      ROLE_A_CLK = 2'd1,
      ROLE_B_CLK = 2'd2
   } role_e;
endpackage

// File: rtl/pdm_pin_sync.sv
module pdm_pin_sync #(
   parameter int unsigned STAGES      = 2,
   parameter bit          CAP_ON_RISE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_raw,
   output logic level,
   output logic any_edge,
   output logic cap_edge
);
   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], pin_raw};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign level    = chain_q[STAGES-1];
   assign any_edge = level ^ prev_q;

   generate
      if (CAP_ON_RISE) begin : g_rise
         assign cap_edge = level & ~prev_q;
      end else begin : g_fall
         assign cap_edge = ~level & prev_q;
      end
   endgenerate
endmodule

// File: rtl/pdm_edge_qual.sv
module pdm_edge_qual #(
   parameter int unsigned MAX_GAP     = 16,
   parameter int unsigned LOCK_EDGES  = 16,
   parameter int unsigned LOST_CYCLES = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_edge,
   output logic qualified,
   output logic idle
);
   localparam int unsigned GW = $clog2(LOST_CYCLES + 1);
   localparam int unsigned RW = $clog2(LOCK_EDGES + 1);
   localparam logic [GW-1:0] GAP_LIM  = GW'(MAX_GAP);
   localparam logic [GW-1:0] LOST_LIM = GW'(LOST_CYCLES);
   localparam logic [RW-1:0] RUN_LIM  = RW'(LOCK_EDGES);

   logic [GW-1:0] gap_q;
   logic [RW-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q <= LOST_LIM;
         run_q <= '0;
      end else if (pin_edge) begin
         gap_q <= '0;
         if (gap_q <= GAP_LIM)
            run_q <= (run_q == RUN_LIM) ? run_q : run_q + 1'b1;
         else
            run_q <= RW'(1);
      end else begin
         if (gap_q != LOST_LIM)
            gap_q <= gap_q + 1'b1;
         if (gap_q > GAP_LIM)
            run_q <= '0;
      end
   end

   assign qualified = (run_q == RUN_LIM);
   assign idle      = (gap_q == LOST_LIM);
endmodule

// File: rtl/pdm_role_ctl.sv
module pdm_role_ctl
   import pdm_sense_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] qual,
   input  logic [1:0] idle,
   input  logic [1:0] cap_edge,
   input  logic [1:0] level,
   output logic       pdm_bit,
   output logic       pdm_vld,
   output logic       clk_present,
   output logic       chan_right
);
   role_e role_q, role_d;
   logic  cap_now;
   logic  cap_val;

   always_comb begin
      role_d = role_q;
      unique case (role_q)
         ROLE_NONE: begin
            if (qual[0] && !qual[1])      role_d = ROLE_A_CLK;
            else if (qual[1] && !qual[0]) role_d = ROLE_B_CLK;
         end
         ROLE_A_CLK: if (idle[0]) role_d = ROLE_NONE;
         ROLE_B_CLK: if (idle[1]) role_d = ROLE_NONE;
         default:    role_d = ROLE_NONE;
      endcase
   end

   always_comb begin
      cap_now = 1'b0;
      cap_val = 1'b0;
      if (role_q == ROLE_A_CLK) begin
         cap_now = cap_edge[0];
         cap_val = level[1];
      end else if (role_q == ROLE_B_CLK) begin
         cap_now = cap_edge[1];
         cap_val = level[0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         role_q  <= ROLE_NONE;
         pdm_vld <= 1'b0;
         pdm_bit <= 1'b0;
      end else begin
         role_q  <= role_d;
         pdm_vld <= cap_now;
         if (cap_now)
            pdm_bit <= cap_val;
      end
   end

   assign clk_present = (role_q != ROLE_NONE);
   assign chan_right  = (role_q == ROLE_B_CLK);
endmodule

// File: rtl/pdm_role_sense.sv
module pdm_role_sense #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned MAX_GAP     = 16,
   parameter int unsigned LOCK_EDGES  = 16,
   parameter int unsigned LOST_CYCLES = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_a,
   input  logic pin_b,
   output logic pdm_bit,
   output logic pdm_vld,
   output logic clk_present,
   output logic chan_right
);
   localparam int unsigned NPINS = 2;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (LOCK_EDGES < 2) begin : g_bad_lock
      $error("LOCK_EDGES must be at least 2");
   end
   if (LOST_CYCLES <= MAX_GAP + 1) begin : g_bad_lost
      $error("LOST_CYCLES must exceed MAX_GAP + 1");
   end

   logic [NPINS-1:0] raw_pins;
   logic [NPINS-1:0] lvl;
   logic [NPINS-1:0] any_e;
   logic [NPINS-1:0] cap_e;
   logic [NPINS-1:0] qual;
   logic [NPINS-1:0] idle;

   assign raw_pins = {pin_b, pin_a};

   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      pdm_pin_sync #(
         .STAGES      (SYNC_STAGES),
         .CAP_ON_RISE (i == 0)
      ) u_sync (
         .clk      (clk),
         .rst_n    (rst_n),
         .pin_raw  (raw_pins[i]),
         .level    (lvl[i]),
         .any_edge (any_e[i]),
         .cap_edge (cap_e[i])
      );

      pdm_edge_qual #(
         .MAX_GAP     (MAX_GAP),
         .LOCK_EDGES  (LOCK_EDGES),
         .LOST_CYCLES (LOST_CYCLES)
      ) u_qual (
         .clk       (clk),
         .rst_n     (rst_n),
         .pin_edge  (any_e[i]),
         .qualified (qual[i]),
         .idle      (idle[i])
      );
   end

   pdm_role_ctl u_ctl (
      .clk         (clk),
      .rst_n       (rst_n),
      .qual        (qual),
      .idle        (idle),
      .cap_edge    (cap_e),
      .level       (lvl),
      .pdm_bit     (pdm_bit),
      .pdm_vld     (pdm_vld),
      .clk_present (clk_present),
      .chan_right  (chan_right)
   );
endmodule

// File: rtl/pdm_role_sense_chk.sv
module pdm_role_sense_chk (
   input logic clk,
   input logic rst_n,
   input logic pdm_bit,
   input logic pdm_vld,
   input logic clk_present,
   input logic chan_right
);
   p_reset_clear_r7: assert property (@(posedge clk)
      !rst_n |=> (!clk_present && !chan_right && !pdm_vld && !pdm_bit));

   p_strobe_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pdm_vld |-> clk_present);

   p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pdm_vld |=> !pdm_vld);

   p_chan_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_present && $past(clk_present)) |-> $stable(chan_right));

   p_chan_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_present |-> !chan_right);
endmodule

bind pdm_role_sense pdm_role_sense_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .pdm_bit     (pdm_bit),
   .pdm_vld     (pdm_vld),
   .clk_present (clk_present),
   .chan_right  (chan_right)
);

// File: tb/pdm_role_sense_tb.sv
module pdm_role_sense_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pa = 1'b0;
   logic pb = 1'b0;
   logic pdm_bit, pdm_vld, clk_present, chan_right;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   bit       counting = 1'b0;
   int       cap_n = 0;
   logic [7:0] cap_word = '0;

   // [15] clock on pin B, [14:8] half period in system cycles, [7:0] payload
   localparam logic [15:0] VECS [0:3] = '{
      {1'b0, 7'd4, 8'hA5},
      {1'b1, 7'd4, 8'h3C},
      {1'b0, 7'd6, 8'h96},
      {1'b1, 7'd5, 8'h0F}
   };
   localparam int PRE = 12;
   localparam int PAY = 8;
   localparam int TAIL = 4;

   always #4 clk = ~clk;

   pdm_role_sense dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .pin_a       (pa),
      .pin_b       (pb),
      .pdm_bit     (pdm_bit),
      .pdm_vld     (pdm_vld),
      .clk_present (clk_present),
      .chan_right  (chan_right)
   );

   always @(negedge clk) begin
      if (counting && pdm_vld) begin
         if (cap_n < 8) cap_word[cap_n] = pdm_bit;
         cap_n = cap_n + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic drv(input bit on_b, input bit cv, input bit dv);
      if (on_b) begin pb = cv; pa = dv; end
      else      begin pa = cv; pb = dv; end
   endtask

   task automatic waitn(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic run_session(input bit on_b, input int h, input logic [7:0] pl);
      int tot;
      bit cv;
      bit dv;
      tot = PRE + PAY + TAIL;
      cv = 1'b0;
      dv = 1'b0;
      cap_n = 0;
      cap_word = '0;
      drv(on_b, 1'b0, 1'b0);
      for (int i = 0; i < tot; i++) begin
         cv = 1'b1;
         drv(on_b, cv, dv);
         waitn(h / 2);
         if (on_b && i == PRE)       counting = 1'b1;
         if (on_b && i == PRE + PAY) counting = 1'b0;
         dv = (i >= PRE && i < PRE + PAY) ? ~pl[i - PRE] : 1'b0;
         drv(on_b, cv, dv);
         waitn(h - h / 2);
         cv = 1'b0;
         drv(on_b, cv, dv);
         waitn(h / 2);
         if (!on_b && i + 1 == PRE)       counting = 1'b1;
         if (!on_b && i + 1 == PRE + PAY) counting = 1'b0;
         dv = (i + 1 >= PRE && i + 1 < PRE + PAY) ? pl[i + 1 - PRE] : 1'b0;
         drv(on_b, cv, dv);
         waitn(h - h / 2);
         if (i == PRE + PAY / 2) begin
            chk(clk_present == 1'b1, "R4 lock on regular clock", clk_present, 1);
            if (on_b) chk(chan_right == 1'b1, "R2 right channel", chan_right, 1);
            else      chk(chan_right == 1'b0, "R1 left channel", chan_right, 0);
         end
      end
      counting = 1'b0;
      chk(cap_n == PAY, "R6 one strobe per bit", cap_n, PAY);
      chk(cap_word == (on_b ? ~pl : pl), "R3 captured bits", cap_word, on_b ? ~pl : pl);
      drv(on_b, 1'b0, 1'b0);
      waitn(30);
      chk(clk_present == 1'b1, "R5 held before timeout", clk_present, 1);
      chk(chan_right == on_b, "R5 channel held", chan_right, on_b);
      waitn(100);
      chk(clk_present == 1'b0, "R5 clock loss", clk_present, 0);
      chk(chan_right == 1'b0, "R5 channel cleared", chan_right, 0);
   endtask

   initial begin
      waitn(5);
      chk(clk_present == 1'b0 && pdm_vld == 1'b0, "R7 reset flags", {clk_present, pdm_vld}, 0);
      chk(chan_right == 1'b0 && pdm_bit == 1'b0, "R7 reset outputs", {chan_right, pdm_bit}, 0);
      rst_n = 1'b1;
      waitn(5);

      for (int v = 0; v < 4; v++) begin
         run_session(VECS[v][15], int'(VECS[v][14:8]), VECS[v][7:0]);
      end

      // both pins toggle together: ambiguous, no lock
      for (int i = 0; i < 40; i++) begin
         pa = ~pa; pb = ~pb;
         waitn(4);
      end
      chk(clk_present == 1'b0, "R4 both pins qualify", clk_present, 0);
      pa = 1'b0; pb = 1'b0;
      waitn(100);

      // slow pin: gaps beyond the regular-edge window
      for (int i = 0; i < 24; i++) begin
         pa = ~pa;
         waitn(24);
         if (clk_present) begin
            chk(1'b0, "R8 slow pin locked", 1, 0);
            break;
         end
      end
      chk(clk_present == 1'b0, "R8 slow pin ignored", clk_present, 0);
      chk(pdm_vld == 1'b0, "R6 no strobe without clock", pdm_vld, 0);
      pa = 1'b0;
      waitn(100);

      // reset mid-lock
      run_session(1'b0, 4, 8'h5A);
      for (int i = 0; i < 20; i++) begin
         pb = ~pb;
         waitn(4);
      end
      rst_n = 1'b0;
      waitn(2);
      chk(clk_present == 1'b0 && chan_right == 1'b0, "R7 reset clears lock", {clk_present, chan_right}, 0);
      rst_n = 1'b1;

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end
endmodule